// File: doc/BRIEF.md
# Operand Resolver with Addressing Modes

This block takes the operand fields of an already decoded instruction and turns them into one operand value plus the effective address that produced it. It handles eight addressing modes. Four of them need no memory at all: implied, immediate, register and stack top. Three need one memory read: direct, register indirect and scaled-index displacement. Indirect mode needs two reads, a pointer fetch followed by an operand fetch. Because of this, the time from accept to result depends on the mode and on how quickly the memory answers.

The block drives two combinational register-file read ports, one for the base register and one for the index register. It reads from a single-port memory through a request/grant handshake, and the data comes back later with a valid strobe. It accepts a new instruction only while it is idle. When the result is ready it raises `done` for one cycle, and at that point `operand` and `eff_addr` hold the result. Both outputs keep their values until the next completion.

Top module: `opnd_fetch`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done`, `busy` and `mem_req` are all 0.
- R2: Mode code 0 (implied) completes without any memory request. `done` rises in the cycle after accept with `operand` = 0 and `eff_addr` = 0.
- R3: Mode code 1 (immediate) completes without any memory request. `operand` equals the full field A and `eff_addr` = 0.
- R4: Mode code 4 (register) completes without any memory request. `operand` equals the register selected by the base-select field and `eff_addr` = 0.
- R5: Mode code 7 (stack top) completes without any memory request. `operand` equals the stack-top input and `eff_addr` equals the stack pointer input.
- R6: Mode code 2 (direct) issues exactly one read, at address A. The returned word becomes `operand` and `eff_addr` = A.
- R7: Mode code 5 (register indirect) issues exactly one read, at the address held in the base register. The returned word becomes `operand`.
- R8: Mode code 3 (indirect) issues exactly two reads. The first is at A. The second is at the word the first read returned, and that word is also `eff_addr`. The second word becomes `operand`.
- R9: Mode code 6 (displacement) reads once at displacement + (index register << scale) + base register, computed modulo 2^32. The displacement is A when `short_disp` = 0. When `short_disp` = 1 it is A[7:0] sign-extended. Scale 0 to 3 multiplies the index by 1, 2, 4 or 8.
- R10: `mem_req` stays high with `mem_addr` unchanged until a cycle in which `mem_gnt` is high, for any number of wait cycles.
- R11: Each accepted instruction produces exactly one `done` pulse, and that pulse lasts exactly one cycle.
- R12: A `start` that arrives while `busy` is high is ignored. It does not change the operation in flight and produces no extra completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Present a new instruction (taken only when idle) |
| mode | input | 3 | Addressing mode code (0..7, see requirements) |
| fld_a | input | 32 | Address / immediate / displacement field |
| short_disp | input | 1 | Displacement is the sign-extended low byte of the field |
| base_sel | input | 3 | Base / operand register number |
| idx_sel | input | 3 | Index register number |
| scale | input | 2 | Index shift amount |
| rf_base_addr | output | 3 | Register-file read address, base port |
| rf_base_data | input | 32 | Register-file read data, base port |
| rf_idx_addr | output | 3 | Register-file read address, index port |
| rf_idx_data | input | 32 | Register-file read data, index port |
| sp_val | input | 32 | Current stack pointer |
| stk_top | input | 32 | Current stack-top value |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | An operation is in flight |
| done | output | 1 | One-cycle completion strobe |
| operand | output | 32 | Resolved operand |
| eff_addr | output | 32 | Effective address |

## Verification
Every mode is tried at least once from a vector table, and the memory modes are tried under several grant and response delays. The read counts and read addresses show whether the block took the right path: zero, one or two reads, and the pointer-chasing order in indirect mode. Displacement vectors use negative short displacements, long displacements, every scale value and register values that wrap past 2^32, so that errors in sign extension, shift amount or carry handling show up. Directed cases cover reset, a `start` pulse during a stalled grant, and the single-cycle width of `done`.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

  typedef enum logic [2:0] {
    AM_IMPL = 3'd0,
    AM_IMM  = 3'd1,
    AM_DIR  = 3'd2,
    AM_IND  = 3'd3,
    AM_REG  = 3'd4,
    AM_RIND = 3'd5,
    AM_DISP = 3'd6,
    AM_STK  = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2
  } seq_state_e;

endpackage

// File: rtl/opnd_ea_calc.sv
module opnd_ea_calc
  import opnd_pkg::*;
#(
  parameter int DW  = 32,
  parameter int SW  = 2,
  parameter int SDW = 8
) (
  input  amode_e          mode,
  input  logic [DW-1:0]   fld_a,
  input  logic            short_disp,
  input  logic [DW-1:0]   base_val,
  input  logic [DW-1:0]   idx_val,
  input  logic [SW-1:0]   scale,
  input  logic [DW-1:0]   sp_val,
  input  logic [DW-1:0]   stk_top,
  output logic [DW-1:0]   ea,
  output logic [DW-1:0]   direct_opnd,
  output logic [1:0]      n_reads
);

  // sign-extend the low SDW bits when the short form is selected
  function automatic logic [DW-1:0] ext_disp(input logic [DW-1:0] a, input logic sh);
    if (sh) ext_disp = {{(DW-SDW){a[SDW-1]}}, a[SDW-1:0]};
    else    ext_disp = a;
  endfunction

  function automatic logic [DW-1:0] scaled_idx(input logic [DW-1:0] v, input logic [SW-1:0] s);
    scaled_idx = v << s;
  endfunction

  // two adders, wrapping at the data width
  function automatic logic [DW-1:0] sum3(input logic [DW-1:0] x, input logic [DW-1:0] y,
                                         input logic [DW-1:0] z);
    sum3 = x + y + z;
  endfunction

  always_comb begin
    ea          = '0;
    direct_opnd = '0;
    n_reads     = 2'd0;
    case (mode)
      AM_IMPL: ;
      AM_IMM:  direct_opnd = fld_a;
      AM_REG:  direct_opnd = base_val;
      AM_STK:  begin direct_opnd = stk_top; ea = sp_val; end
      AM_DIR:  begin ea = fld_a;    n_reads = 2'd1; end
      AM_IND:  begin ea = fld_a;    n_reads = 2'd2; end
      AM_RIND: begin ea = base_val; n_reads = 2'd1; end
      AM_DISP: begin
        ea      = sum3(ext_disp(fld_a, short_disp), scaled_idx(idx_val, scale), base_val);
        n_reads = 2'd1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/opnd_seq.sv
module opnd_seq
  import opnd_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] ea_in,
  input  logic [DW-1:0] direct_opnd,
  input  logic [1:0]    n_reads,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] operand,
  output logic [DW-1:0] eff_addr
);

  seq_state_e    state;
  logic [DW-1:0] addr_q;
  logic          hop_q;

  // named events for the checks
  logic accept, grant_ev, resp_ev, hop_ev;
  assign accept   = (state == S_IDLE) && start;
  assign grant_ev = (state == S_REQ) && mem_gnt;
  assign resp_ev  = (state == S_WAIT) && mem_rvalid;
  assign hop_ev   = resp_ev && hop_q;

  assign mem_req  = (state == S_REQ);
  assign mem_addr = addr_q;
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      addr_q   <= '0;
      hop_q    <= 1'b0;
      done     <= 1'b0;
      operand  <= '0;
      eff_addr <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          if (n_reads == 2'd0) begin
            operand  <= direct_opnd;
            eff_addr <= ea_in;
            done     <= 1'b1;
          end else begin
            addr_q <= ea_in;
            hop_q  <= (n_reads == 2'd2);
            state  <= S_REQ;
          end
        end
        S_REQ: if (grant_ev) state <= S_WAIT;
        S_WAIT: if (resp_ev) begin
          if (hop_q) begin
            addr_q <= mem_rdata;
            hop_q  <= 1'b0;
            state  <= S_REQ;
          end else begin
            operand  <= mem_rdata;
            eff_addr <= addr_q;
            done     <= 1'b1;
            state    <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fast_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && n_reads == 2'd0) |=> (done && !busy));

  assert_ptr_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hop_ev |=> (mem_req && mem_addr == $past(mem_rdata)));

  assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && start) |=> (mem_req && $stable(mem_addr)));

endmodule

// File: rtl/opnd_fetch.sv
module opnd_fetch
  import opnd_pkg::*;
#(
  parameter int DW  = 32,
  parameter int RW  = 3,
  parameter int SW  = 2,
  parameter int SDW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [DW-1:0] fld_a,
  input  logic          short_disp,
  input  logic [RW-1:0] base_sel,
  input  logic [RW-1:0] idx_sel,
  input  logic [SW-1:0] scale,
  output logic [RW-1:0] rf_base_addr,
  input  logic [DW-1:0] rf_base_data,
  output logic [RW-1:0] rf_idx_addr,
  input  logic [DW-1:0] rf_idx_data,
  input  logic [DW-1:0] sp_val,
  input  logic [DW-1:0] stk_top,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] operand,
  output logic [DW-1:0] eff_addr
);

  amode_e        mode_e;
  logic [DW-1:0] ea_w, dop_w;
  logic [1:0]    nrd_w;

  assign mode_e       = amode_e'(mode);
  assign rf_base_addr = base_sel;
  assign rf_idx_addr  = idx_sel;

  opnd_ea_calc #(.DW(DW), .SW(SW), .SDW(SDW)) u_calc (
    .mode        (mode_e),
    .fld_a       (fld_a),
    .short_disp  (short_disp),
    .base_val    (rf_base_data),
    .idx_val     (rf_idx_data),
    .scale       (scale),
    .sp_val      (sp_val),
    .stk_top     (stk_top),
    .ea          (ea_w),
    .direct_opnd (dop_w),
    .n_reads     (nrd_w)
  );

  opnd_seq #(.DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .ea_in       (ea_w),
    .direct_opnd (dop_w),
    .n_reads     (nrd_w),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_gnt     (mem_gnt),
    .mem_rvalid  (mem_rvalid),
    .mem_rdata   (mem_rdata),
    .busy        (busy),
    .done        (done),
    .operand     (operand),
    .eff_addr    (eff_addr)
  );

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> (!mem_req));

endmodule

// File: tb/opnd_fetch_bench.sv
module opnd_fetch_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [31:0] fld_a = '0;
  logic        short_disp = 1'b0;
  logic [2:0]  base_sel = '0, idx_sel = '0;
  logic [1:0]  scale = '0;
  logic [2:0]  rf_base_addr, rf_idx_addr;
  logic [31:0] rf_base_data, rf_idx_data;
  logic [31:0] sp_val = 32'h0000_7FF0;
  logic [31:0] stk_top = 32'hCAFE_0011;
  logic        mem_req, mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        busy, done;
  logic [31:0] operand, eff_addr;

  always #2.5 clk = ~clk;  // 200 MHz

  function automatic logic [31:0] regv(input logic [2:0] i);
    logic [31:0] m;
    m = 32'h2345_6789 * (32'(i) + 32'd1);
    return m;
  endfunction

  function automatic logic [31:0] memv(input logic [31:0] a);
    return {a[15:0] ^ 16'h3C5A, a[31:16] + 16'h0101};
  endfunction

  assign rf_base_data = regv(rf_base_addr);
  assign rf_idx_data  = regv(rf_idx_addr);

  opnd_fetch u_opnd_fetch (
    .clk, .rst_n, .start, .mode, .fld_a, .short_disp, .base_sel, .idx_sel, .scale,
    .rf_base_addr, .rf_base_data, .rf_idx_addr, .rf_idx_data, .sp_val, .stk_top,
    .mem_req, .mem_addr, .mem_gnt, .mem_rvalid, .mem_rdata,
    .busy, .done, .operand, .eff_addr
  );

  int total = 0, bad = 0;
  int gd = 0, rd = 1;
  int rd_cnt = 0, hold_bad = 0, done_cnt = 0;
  logic [31:0] alog [4];
  bit finished = 0;

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        logic [31:0] a0;
        a0 = mem_addr;
        for (int k = 0; k < gd; k++) begin
          @(negedge clk);
          if (!mem_req || mem_addr != a0) hold_bad++;
        end
        mem_gnt = 1'b1;
        if (rd_cnt < 4) alog[rd_cnt] = a0;
        rd_cnt++;
        @(negedge clk);
        mem_gnt = 1'b0;
        for (int k = 1; k < rd; k++) @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata  = memv(a0);
        @(negedge clk);
        mem_rvalid = 1'b0;
      end
    end
  end

  always @(negedge clk) if (done) done_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0]  md;
    logic [31:0] a;
    logic        sh;
    logic [2:0]  b;
    logic [2:0]  x;
    logic [1:0]  sc;
    logic [3:0]  g;
    logic [3:0]  r;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'h1234_5678, 1'b0, 3'd1, 3'd2, 2'd0, 4'd0, 4'd1},  // R2 implied
    '{3'd1, 32'hDEAD_BEEF, 1'b1, 3'd0, 3'd0, 2'd0, 4'd0, 4'd1},  // R3 immediate
    '{3'd4, 32'h0000_0000, 1'b0, 3'd5, 3'd0, 2'd0, 4'd0, 4'd1},  // R4 register
    '{3'd7, 32'h0000_0055, 1'b0, 3'd0, 3'd0, 2'd0, 4'd0, 4'd1},  // R5 stack
    '{3'd2, 32'h0000_1000, 1'b0, 3'd0, 3'd0, 2'd0, 4'd0, 4'd1},  // R6 direct, fast
    '{3'd2, 32'hFFFF_FFFC, 1'b0, 3'd0, 3'd0, 2'd0, 4'd3, 4'd2},  // R6 direct, slow
    '{3'd5, 32'h0000_0000, 1'b0, 3'd3, 3'd0, 2'd0, 4'd1, 4'd1},  // R7 reg indirect
    '{3'd3, 32'h0000_0200, 1'b0, 3'd0, 3'd0, 2'd0, 4'd0, 4'd1},  // R8 indirect
    '{3'd3, 32'hABCD_0004, 1'b0, 3'd0, 3'd0, 2'd0, 4'd2, 4'd3},  // R8 indirect, slow
    '{3'd6, 32'h0000_00F0, 1'b1, 3'd1, 3'd2, 2'd3, 4'd0, 4'd1},  // R9 neg short, x8
    '{3'd6, 32'h0000_00F0, 1'b0, 3'd1, 3'd2, 2'd0, 4'd1, 4'd1},  // R9 long, x1
    '{3'd6, 32'h1234_567F, 1'b1, 3'd7, 3'd6, 2'd2, 4'd0, 4'd2},  // R9 pos short, x4, wrap
    '{3'd6, 32'h8000_0000, 1'b0, 3'd6, 3'd7, 2'd1, 4'd2, 4'd1},  // R9 long, x2, wrap
    '{3'd6, 32'hFFFF_FF80, 1'b1, 3'd0, 3'd0, 2'd1, 4'd0, 4'd1}   // R9 short -128, same reg
  };

  task automatic issue(input vec_t v);
    @(negedge clk);
    mode = v.md; fld_a = v.a; short_disp = v.sh; base_sel = v.b; idx_sel = v.x;
    scale = v.sc; gd = int'(v.g); rd = int'(v.r); rd_cnt = 0; done_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 200 && !done; k++) @(negedge clk);
  endtask

  initial begin
    #1;
    chk("R1 done in reset", {31'd0, done}, 32'd0);
    chk("R1 busy in reset", {31'd0, busy}, 32'd0);
    chk("R1 req in reset", {31'd0, mem_req}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 quiet after reset", {29'd0, done, busy, mem_req}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [31:0] e_op, e_ea, disp, a1;
      int e_rd;
      string tag;
      v = VECS[i];
      e_rd = 1; e_op = '0; e_ea = '0; a1 = '0;
      case (v.md)
        3'd0: begin e_rd = 0; tag = "R2"; end
        3'd1: begin e_rd = 0; e_op = v.a; tag = "R3"; end
        3'd4: begin e_rd = 0; e_op = regv(v.b); tag = "R4"; end
        3'd7: begin e_rd = 0; e_op = stk_top; e_ea = sp_val; tag = "R5"; end
        3'd2: begin e_ea = v.a; tag = "R6"; end
        3'd5: begin e_ea = regv(v.b); tag = "R7"; end
        3'd3: begin e_rd = 2; a1 = v.a; e_ea = memv(v.a); tag = "R8"; end
        default: begin
          disp = v.sh ? 32'($signed(v.a[7:0])) : v.a;
          e_ea = disp + regv(v.x) * (32'd1 << v.sc) + regv(v.b);
          tag = "R9";
        end
      endcase
      if (e_rd > 0) e_op = memv(e_ea);
      issue(v);
      if (e_rd == 0) chk({tag, " done next cycle"}, {31'd0, done}, 32'd1);
      wait_done();
      chk({tag, " operand"}, operand, e_op);
      chk({tag, " eff_addr"}, eff_addr, e_ea);
      chk({tag, " read count"}, 32'(rd_cnt), 32'(e_rd));
      if (e_rd == 2) chk("R8 first read addr", alog[0], a1);
      if (e_rd >= 1) chk({tag, " read addr"}, alog[e_rd-1], e_ea);
      @(negedge clk);
      chk("R11 done single cycle", {31'd0, done}, 32'd0);
      chk("R11 one done pulse", 32'(done_cnt), 32'd1);
    end
    chk("R10 request held until grant", 32'(hold_bad), 32'd0);

    // R12: start while stalled on grant
    begin
      vec_t v;
      v = '{3'd2, 32'h0000_0040, 1'b0, 3'd0, 3'd0, 2'd0, 4'd6, 4'd1};
      issue(v);
      @(negedge clk);
      mode = 3'd1; fld_a = 32'h0000_0099; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      chk("R12 operand unchanged by busy start", operand, memv(32'h40));
      chk("R12 one read", 32'(rd_cnt), 32'd1);
      repeat (5) @(negedge clk);
      chk("R12 no extra done", 32'(done_cnt), 32'd1);
      chk("R10 held through long stall", 32'(hold_bad), 32'd0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule